// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between the 32-bit register datapath of a simple RISC core and a word-wide data memory. It forms the effective address from a base register and a signed 16-bit displacement. It presents the word-aligned address to the memory. For stores, it steers the source data onto the proper byte lanes and raises matching per-byte write enables. For loads, it selects the addressed bytes from the returned memory word and sign- or zero-extends them into a registered 32-bit result.

Lanes are numbered big-endian: the byte at address offset 0 inside a word occupies bits 31:24. Every access must be naturally aligned. Any access that breaks that rule is suppressed: no byte is written, a load returns zero, and a one-cycle error pulse is raised in the cycle after the request. The memory read is combinational, so the word on `mem_rdata` belongs to the address on `mem_addr` in the same cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base_addr` plus `offset` sign-extended to 32 bits. `mem_addr` carries that address with its two low bits forced to zero, in the same cycle as the request.
- R2: A word load (`acc_size` = 2'b10) returns `mem_rdata` unchanged on `load_data`, with `load_valid` high, in the cycle after the request.
- R3: Lanes are big-endian. A byte at offset 0, 1, 2 or 3 is taken from bits 31:24, 23:16, 15:8 or 7:0. A halfword at offset 0 or 2 is taken from bits 31:16 or 15:0.
- R4: When `is_unsigned` is 0, a byte load (`acc_size` = 2'b00) or halfword load (2'b01) sign-extends the selected bits to 32 bits.
- R5: When `is_unsigned` is 1, byte and halfword loads zero-extend the selected bits to 32 bits. `is_unsigned` has no effect on word loads.
- R6: A byte store drives the low 8 bits of `store_data` on every lane of `mem_wdata`. It raises exactly one bit of `mem_be`: bit 3 for offset 0, down to bit 0 for offset 3.
- R7: A halfword store drives the low 16 bits of `store_data` on both halves, with `mem_be` = 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store drives `store_data` unchanged with `mem_be` = 4'b1111.
- R8: An access is misaligned when it is a halfword at an odd address, a word at an address that is not a multiple of 4, or any access with `acc_size` = 2'b11. A misaligned access holds `mem_be` at zero and raises `misalign_err` for exactly the following cycle.
- R9: A misaligned load still raises `load_valid` in the following cycle, with `load_data` equal to zero.
- R10: When there is no request, or the request is a load, `mem_be` is zero. In the cycle after a cycle with no request, `load_valid` and `misalign_err` are low.
- R11: While `rst_n` is low, `load_valid`, `misalign_err` and `load_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is requested this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| is_unsigned | input | 1 | Zero-extend sub-word loads |
| store_data | input | 32 | Source register for stores |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_be | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| load_data | output | 32 | Registered extended load result |
| load_valid | output | 1 | Load result valid, one cycle after request |
| misalign_err | output | 1 | One-cycle pulse after a misaligned access |

## Verification
The assertions check the following on every cycle:
- write enables stay clear for loads, idle cycles and misaligned accesses;
- an aligned byte store raises exactly one enable;
- a load request is followed by `load_valid`, and a misaligned request by `misalign_err`;
- nothing is pulsed after an idle cycle;
- a misaligned load returns zero.

Only the bench scenarios can show that the right lane is chosen for each offset, that the extension follows `is_unsigned`, that store data lands on the right bits, and that negative displacements form the correct address.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int LW    = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0] load_data;
        logic            load_valid;
        logic            err;
    } rsp_state_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  disp,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LW-1:0]     lane,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff_d;

    always_comb begin
        eff_d     = base + {{EXT_W{disp[OFF_W-1]}}, disp};
        lane      = eff_d[LW-1:0];
        word_addr = {eff_d[ADDR_W-1:LW], {LW{1'b0}}};
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = eff_d[0];
            SZ_WORD: misaligned = |eff_d[LW-1:0];
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic [LW-1:0]   lane,
    input  logic [1:0]      size,
    input  logic            zext,
    output logic [XLEN-1:0] result
);
    logic [7:0]  lane_byte [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word[XLEN-1-8*g -: 8];
    end

    always_comb begin
        pick_b = lane_byte[lane];
        pick_h = {lane_byte[{lane[LW-1], 1'b0}], lane_byte[{lane[LW-1], 1'b1}]};
        case (size)
            SZ_BYTE: result = zext ? {{(XLEN-8){1'b0}}, pick_b}
                                   : {{(XLEN-8){pick_b[7]}}, pick_b};
            SZ_HALF: result = zext ? {{(XLEN-16){1'b0}}, pick_h}
                                   : {{(XLEN-16){pick_h[15]}}, pick_h};
            SZ_WORD: result = word;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_lane_pkg::*;
(
    input  logic [XLEN-1:0]  src,
    input  logic [LW-1:0]    lane,
    input  logic [1:0]       size,
    input  logic             allow,
    output logic [XLEN-1:0]  wdata,
    output logic [LANES-1:0] be
);
    logic [LANES-1:0] be_raw;

    always_comb begin
        case (size)
            SZ_BYTE: begin
                wdata  = {LANES{src[7:0]}};
                be_raw = LANES'(1) << (LANES - 1 - int'(lane));
            end
            SZ_HALF: begin
                wdata  = {(LANES/2){src[15:0]}};
                be_raw = lane[LW-1] ? LANES'(4'b0011) : LANES'(4'b1100);
            end
            SZ_WORD: begin
                wdata  = src;
                be_raw = '1;
            end
            default: begin
                wdata  = src;
                be_raw = '0;
            end
        endcase
        be = allow ? be_raw : '0;
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        acc_size,
    input  logic              is_unsigned,
    input  logic [XLEN-1:0]   store_data,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [LANES-1:0]  mem_be,
    output logic [XLEN-1:0]   load_data,
    output logic              load_valid,
    output logic              misalign_err
);
    logic [LW-1:0]   lane;
    logic            bad;
    logic [XLEN-1:0] extracted;
    rsp_state_t      st_d, st_q;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base       (base_addr),
        .disp       (offset),
        .size       (acc_size),
        .word_addr  (mem_addr),
        .lane       (lane),
        .misaligned (bad)
    );

    lsu_load_extract u_load (
        .word   (mem_rdata),
        .lane   (lane),
        .size   (acc_size),
        .zext   (is_unsigned),
        .result (extracted)
    );

    lsu_store_lanes u_store (
        .src   (store_data),
        .lane  (lane),
        .size  (acc_size),
        .allow (req_valid && req_write && !bad),
        .wdata (mem_wdata),
        .be    (mem_be)
    );

    always_comb begin
        st_d            = '0;
        st_d.load_valid = req_valid && !req_write;
        st_d.err        = req_valid && bad;
        if (req_valid && !req_write && !bad) begin
            st_d.load_data = extracted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_data    = st_q.load_data;
    assign load_valid   = st_q.load_valid;
    assign misalign_err = st_q.err;

    // R8
    be_blocked_on_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |-> (mem_be == '0));

    // R10
    be_idle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_write) |-> (mem_be == '0));

    // R6
    byte_be_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !bad && acc_size == SZ_BYTE) |-> ($countones(mem_be) == 1));

    // R2
    valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> load_valid);

    // R8
    err_after_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |=> misalign_err);

    // R10
    quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!load_valid && !misalign_err));

    // R9
    zero_on_bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && bad) |=> (load_data == '0));
endmodule

// File: tb/lsu_lane_align_test.sv
module lsu_lane_align_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [1:0]  acc_size = '0;
    logic        is_unsigned = 1'b0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] load_data;
    logic        load_valid;
    logic        misalign_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        valid;
        logic        err;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    lsu_lane_align uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .base_addr(base_addr), .offset(offset), .acc_size(acc_size),
        .is_unsigned(is_unsigned), .store_data(store_data), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .load_data(load_data), .load_valid(load_valid), .misalign_err(misalign_err)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] eff(logic [31:0] b, logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    function automatic logic is_bad(logic [31:0] a, logic [1:0] s);
        if (s == 2'b11) return 1'b1;
        if (s == 2'b01) return a[0];
        if (s == 2'b10) return a[1:0] != 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [31:0] ref_load(logic [31:0] w, logic [1:0] off, logic [1:0] s, logic u);
        logic [31:0] sh;
        if (s == 2'b10) return w;
        if (s == 2'b00) begin
            sh = w >> (8 * (3 - off));
            return u ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
        end
        sh = w >> (off[1] ? 0 : 16);
        return u ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    endfunction

    task automatic do_load(string tag, logic [31:0] b, logic [15:0] o, logic [1:0] s, logic u, logic [31:0] w);
        logic [31:0] a;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; base_addr = b; offset = o;
        acc_size = s; is_unsigned = u; mem_rdata = w; store_data = 32'hFFFF_FFFF;
        #1;
        a = eff(b, o);
        check({tag, " R1 addr"}, mem_addr, {a[31:2], 2'b00});
        check({tag, " R10 be on load"}, {28'h0, mem_be}, 32'h0);
        e.valid = 1'b1;
        e.err   = is_bad(a, s);
        e.data  = e.err ? 32'h0 : ref_load(w, a[1:0], s, u);
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic do_store(string tag, logic [31:0] b, logic [15:0] o, logic [1:0] s, logic [31:0] d);
        logic [31:0] a;
        logic [3:0]  be;
        logic [31:0] wd;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; base_addr = b; offset = o;
        acc_size = s; is_unsigned = 1'b0; store_data = d; mem_rdata = 32'h0;
        #1;
        a = eff(b, o);
        case (s)
            2'b00: begin be = 4'b1000 >> a[1:0]; wd = {4{d[7:0]}}; end
            2'b01: begin be = a[1] ? 4'b0011 : 4'b1100; wd = {2{d[15:0]}}; end
            default: begin be = 4'b1111; wd = d; end
        endcase
        if (is_bad(a, s)) be = 4'b0000;
        check({tag, " R1 addr"}, mem_addr, {a[31:2], 2'b00});
        check({tag, " R6/R7/R8 be"}, {28'h0, mem_be}, {28'h0, be});
        if (be != 4'b0000) begin
            for (int i = 0; i < 4; i++) begin
                if (be[i]) check({tag, " R6/R7 wdata lane"},
                                 {24'h0, mem_wdata[8*i +: 8]}, {24'h0, wd[8*i +: 8]});
            end
        end
        e.valid = 1'b0;
        e.err   = is_bad(a, s);
        e.data  = 32'h0;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic do_idle(string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b1; acc_size = 2'b10; store_data = 32'hA5A5_A5A5;
        #1;
        check({tag, " R10 idle be"}, {28'h0, mem_be}, 32'h0);
        e.valid = 1'b0; e.err = 1'b0; e.data = 32'h0; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares the registered response to the queued expectation
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " valid"}, {31'h0, load_valid}, {31'h0, e.valid});
            check({e.tag, " R8 err"}, {31'h0, misalign_err}, {31'h0, e.err});
            if (e.valid) check({e.tag, " data"}, load_data, e.data);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; acc_size = 2'b11;
        @(negedge clk);
        check("R11 reset load_valid", {31'h0, load_valid}, 32'h0);
        check("R11 reset err", {31'h0, misalign_err}, 32'h0);
        check("R11 reset data", load_data, 32'h0);
        req_valid = 1'b0;
        rst_n = 1'b1;

        do_load("R2 word", 32'h0000_1000, 16'h0008, 2'b10, 1'b0, 32'hDEAD_BEEF);
        do_load("R5 word unsigned flag", 32'h0000_1000, 16'h0004, 2'b10, 1'b1, 32'h8123_4567);
        for (int k = 0; k < 4; k++) begin
            do_load("R3 R4 byte signed", 32'h0000_2000, 16'(k), 2'b00, 1'b0, 32'h80F1_7F92);
            do_load("R3 R5 byte unsigned", 32'h0000_2000, 16'(k), 2'b00, 1'b1, 32'h80F1_7F92);
        end
        do_load("R3 R4 half0 signed", 32'h0000_3000, 16'h0000, 2'b01, 1'b0, 32'h9ABC_1234);
        do_load("R3 R4 half2 signed", 32'h0000_3000, 16'h0002, 2'b01, 1'b0, 32'h1234_F00D);
        do_load("R3 R5 half0 unsigned", 32'h0000_3000, 16'h0000, 2'b01, 1'b1, 32'h9ABC_1234);
        do_load("R3 R4 half2 positive", 32'h0000_3000, 16'h0002, 2'b01, 1'b0, 32'hFFFF_7001);
        do_load("R1 negative disp", 32'h0000_4010, 16'hFFF4, 2'b10, 1'b0, 32'h0102_0304);
        do_load("R1 carry across", 32'h0000_FFFE, 16'h0003, 2'b00, 1'b1, 32'hAABB_CCDD);
        do_load("R8 R9 half odd", 32'h0000_5000, 16'h0001, 2'b01, 1'b0, 32'hFFFF_FFFF);
        do_load("R8 R9 word off2", 32'h0000_5000, 16'h0002, 2'b10, 1'b0, 32'hFFFF_FFFF);
        do_load("R8 R9 size11", 32'h0000_5000, 16'h0000, 2'b11, 1'b0, 32'hFFFF_FFFF);
        do_idle("R10 idle a");
        for (int k = 0; k < 4; k++)
            do_store("R6 byte", 32'h0000_6000, 16'(k), 2'b00, 32'h1234_56C7);
        do_store("R7 half0", 32'h0000_6000, 16'h0000, 2'b01, 32'hDEAD_BEEF);
        do_store("R7 half2", 32'h0000_6000, 16'h0002, 2'b01, 32'hDEAD_BEEF);
        do_store("R7 word", 32'h0000_6000, 16'h0004, 2'b10, 32'hCAFE_F00D);
        do_store("R8 half odd store", 32'h0000_6000, 16'h0003, 2'b01, 32'h1111_2222);
        do_store("R8 word off1 store", 32'h0000_6001, 16'h0000, 2'b10, 32'h3333_4444);
        do_store("R8 size11 store", 32'h0000_6000, 16'h0000, 2'b11, 32'h5555_6666);
        do_idle("R10 idle b");
        do_load("R2 after store", 32'h0000_7000, 16'h0000, 2'b10, 1'b0, 32'h7654_3210);
        do_idle("R10 idle c");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule